// File: doc/BRIEF.md
# Dual-Channel Split-Bus Arbiter

This block is the central arbiter of an on-chip bus whose address and data phases travel on separate paths. It contains two arbiters that run side by side every cycle. The first arbiter looks at the address-bus requests from up to fifteen agents. It returns a registered one-hot address grant, together with an address strobe that marks the cycle in which a command tenure begins. The granted agent drives its command on the cycle after the strobe. The second arbiter does the same for data-bus requests. It returns a registered one-hot data grant and a data-start pulse in that same cycle.

Both arbiters use round-robin. Priority begins at the agent after the one granted last and wraps from the top agent back to agent 0. A software-controlled enable vector masks agents out of both arbiters. When no enabled agent is requesting, each arbiter parks its grant on its last owner and keeps its strobe low.

The block also merges the qualifier signals. It ORs the qualifier fields that each agent drives for the address phase and for the data phase, and returns the combined values to every agent. This path is combinational. The block has no data stream of its own, so every pin is plain level control without a valid/ready handshake.

Top module: `split_bus_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both grant vectors, the address strobe and the data-start pulse are all zero.
- R2: Each grant vector is at all times either all-zero or has exactly one bit set.
- R3: Address round-robin: at each clock edge, the address winner is the first agent with an enabled request, searching upward from the pointer index and wrapping from 14 to 0. The pointer is 0 after reset and becomes winner+1 (modulo 15) after each address grant.
- R4: The address strobe is high for exactly the cycles whose address grant was won at the preceding edge. The granted bit (agent k drives bit k) is set in those same cycles.
- R5: Address parking: when no enabled agent requests at an edge, the address strobe is low afterwards and the address grant keeps its previous value. The only exception is that bits of agents which are currently disabled are cleared.
- R6: An agent whose enable bit is 0 at an edge is never given a new address grant at that edge.
- R7: Data round-robin follows the R3 rule using its own pointer and data requests. A disabled agent never receives a new data grant.
- R8: The data-start pulse rises in exactly the cycles in which a new data grant is issued. With no enabled data request, the data grant parks as in R5 and data-start is low.
- R9: The address and data arbiters are independent. The outcome of one never depends on the requests or pointer of the other.
- R10: Grant and strobe outputs are registered. A change of request inputs between edges does not change them before the next rising edge.
- R11: Each qualifier output is the bitwise OR of the matching field of all agents (agent i occupies bits [i*W +: W]). It follows the inputs without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| agent_en | input | N_AGENTS | Per-agent enable, bit k for agent k |
| addr_req | input | N_AGENTS | Address-bus requests |
| data_req | input | N_AGENTS | Data-bus requests |
| addr_qual_in | input | N_AGENTS*AQ_W | Per-agent address qualifier fields |
| data_qual_in | input | N_AGENTS*DQ_W | Per-agent data qualifier fields |
| addr_gnt | output | N_AGENTS | Registered one-hot address grant |
| addr_strobe | output | 1 | Address tenure start, registered |
| data_gnt | output | N_AGENTS | Registered one-hot data grant |
| data_start | output | 1 | Data transfer start, registered |
| addr_qual_out | output | AQ_W | OR of all address qualifier fields |
| data_qual_out | output | DQ_W | OR of all data qualifier fields |

## Verification
The checker enforces several properties on every cycle: grants are one-hot or zero, each strobe carries exactly one grant bit, a strobe only follows an edge with an enabled request, a new grant bit always belongs to an agent that was requesting and enabled, and a grant without a strobe never gains a bit. These properties cannot tell which of several requesters should have won. The round-robin order, the wrap from 14 to 0, the pointer value after reset and the independence of the two channels are therefore shown only by the bench's sweeps against its arithmetic model. The same holds for the qualifier OR.

// File: rtl/sba_pkg.sv
package sba_pkg;
  parameter int unsigned SBA_AGENTS_DEFAULT = 15;
  parameter int unsigned SBA_QUAL_W_DEFAULT = 4;

  function automatic int unsigned sba_idx_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/sba_rr_pick.sv
module sba_rr_pick #(
  parameter int unsigned N  = 15,
  parameter int unsigned IW = 4
) (
  input  logic [N-1:0]  cand_vec,
  input  logic [IW-1:0] start_idx,
  output logic          found,
  output logic [IW-1:0] win_idx
);
  logic [IW:0] probe;

  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    probe   = '0;
    for (int i = 0; i < int'(N); i++) begin
      probe = {1'b0, start_idx} + (IW+1)'(i);
      if (probe >= (IW+1)'(N)) probe = probe - (IW+1)'(N);
      if (!found && cand_vec[probe[IW-1:0]]) begin
        found   = 1'b1;
        win_idx = probe[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/sba_rr_channel.sv
module sba_rr_channel #(
  parameter int unsigned N = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] enable,
  output logic [N-1:0] gnt,
  output logic         fire
);
  localparam int unsigned IW = sba_pkg::sba_idx_w(N);

  logic [N-1:0]  elig;
  logic [IW-1:0] ptr_q;
  logic          hit;
  logic [IW-1:0] win;
  logic [N-1:0]  gnt_q;
  logic          fire_q;

  assign elig = req & enable;

  sba_rr_pick #(.N(N), .IW(IW)) u_pick (
    .cand_vec (elig),
    .start_idx(ptr_q),
    .found    (hit),
    .win_idx  (win)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      fire_q <= 1'b0;
      ptr_q  <= '0;
    end else if (hit) begin
      gnt_q  <= N'(1) << win;
      fire_q <= 1'b1;
      ptr_q  <= (win == IW'(N-1)) ? '0 : win + IW'(1);
    end else begin
      gnt_q  <= gnt_q & enable;
      fire_q <= 1'b0;
    end
  end

  assign gnt  = gnt_q;
  assign fire = fire_q;
endmodule

// File: rtl/sba_qual_or.sv
module sba_qual_or #(
  parameter int unsigned N = 15,
  parameter int unsigned W = 4
) (
  input  logic [N*W-1:0] fields,
  output logic [W-1:0]   merged
);
  always_comb begin
    merged = '0;
    for (int i = 0; i < int'(N); i++) begin
      merged = merged | fields[i*W +: W];
    end
  end
endmodule

// File: rtl/split_bus_arbiter.sv
module split_bus_arbiter #(
  parameter int unsigned N_AGENTS = sba_pkg::SBA_AGENTS_DEFAULT,
  parameter int unsigned AQ_W     = sba_pkg::SBA_QUAL_W_DEFAULT,
  parameter int unsigned DQ_W     = sba_pkg::SBA_QUAL_W_DEFAULT
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_AGENTS-1:0]      agent_en,
  input  logic [N_AGENTS-1:0]      addr_req,
  input  logic [N_AGENTS-1:0]      data_req,
  input  logic [N_AGENTS*AQ_W-1:0] addr_qual_in,
  input  logic [N_AGENTS*DQ_W-1:0] data_qual_in,
  output logic [N_AGENTS-1:0]      addr_gnt,
  output logic                     addr_strobe,
  output logic [N_AGENTS-1:0]      data_gnt,
  output logic                     data_start,
  output logic [AQ_W-1:0]          addr_qual_out,
  output logic [DQ_W-1:0]          data_qual_out
);
  sba_rr_channel #(.N(N_AGENTS)) u_addr_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (addr_req),
    .enable(agent_en),
    .gnt   (addr_gnt),
    .fire  (addr_strobe)
  );

  sba_rr_channel #(.N(N_AGENTS)) u_data_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (data_req),
    .enable(agent_en),
    .gnt   (data_gnt),
    .fire  (data_start)
  );

  sba_qual_or #(.N(N_AGENTS), .W(AQ_W)) u_aq_or (
    .fields(addr_qual_in),
    .merged(addr_qual_out)
  );

  sba_qual_or #(.N(N_AGENTS), .W(DQ_W)) u_dq_or (
    .fields(data_qual_in),
    .merged(data_qual_out)
  );
endmodule

// File: rtl/sba_checker.sv
module sba_checker #(
  parameter int unsigned N = 15
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] agent_en,
  input logic [N-1:0] addr_req,
  input logic [N-1:0] data_req,
  input logic [N-1:0] addr_gnt,
  input logic         addr_strobe,
  input logic [N-1:0] data_gnt,
  input logic         data_start
);
  AST_ADDR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(addr_gnt)); // R2
  AST_DATA_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(data_gnt)); // R2
  AST_STROBE_ONE_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe |-> ($countones(addr_gnt) == 1)); // R4
  AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe |-> $past(|(addr_req & agent_en))); // R4
  AST_ADDR_GNT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe |-> ((addr_gnt & ~$past(addr_req & agent_en)) == '0)); // R6
  AST_ADDR_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_strobe |-> ((addr_gnt & ~$past(addr_gnt)) == '0)); // R5
  AST_DSTART_ONE_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    data_start |-> ($countones(data_gnt) == 1)); // R8
  AST_DATA_GNT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    data_start |-> ((data_gnt & ~$past(data_req & agent_en)) == '0)); // R7
  AST_DATA_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    !data_start |-> ((data_gnt & ~$past(data_gnt)) == '0)); // R8
endmodule

bind split_bus_arbiter sba_checker #(.N(N_AGENTS)) u_sba_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .agent_en   (agent_en),
  .addr_req   (addr_req),
  .data_req   (data_req),
  .addr_gnt   (addr_gnt),
  .addr_strobe(addr_strobe),
  .data_gnt   (data_gnt),
  .data_start (data_start)
);

// File: tb/split_bus_arbiter_test.sv
`timescale 1ns/1ps
module split_bus_arbiter_test;
  localparam int N  = 15;
  localparam int QW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  agent_en = '0;
  logic [N-1:0]  addr_req = '0;
  logic [N-1:0]  data_req = '0;
  logic [N*QW-1:0] addr_qual_in = '0;
  logic [N*QW-1:0] data_qual_in = '0;
  logic [N-1:0]  addr_gnt;
  logic          addr_strobe;
  logic [N-1:0]  data_gnt;
  logic          data_start;
  logic [QW-1:0] addr_qual_out;
  logic [QW-1:0] data_qual_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int            pa, pd;
  logic [N-1:0]  mag, mdg;
  logic [31:0]   seed = 32'h1ACE_B00C;

  always #4 clk = ~clk;

  split_bus_arbiter #(.N_AGENTS(N), .AQ_W(QW), .DQ_W(QW)) uut (
    .clk(clk), .rst_n(rst_n), .agent_en(agent_en),
    .addr_req(addr_req), .data_req(data_req),
    .addr_qual_in(addr_qual_in), .data_qual_in(data_qual_in),
    .addr_gnt(addr_gnt), .addr_strobe(addr_strobe),
    .data_gnt(data_gnt), .data_start(data_start),
    .addr_qual_out(addr_qual_out), .data_qual_out(data_qual_out)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int pick(input logic [N-1:0] r, input int p);
    for (int i = 0; i < N; i++) begin
      if (r[(p + i) % N]) return (p + i) % N;
    end
    return -1;
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  task automatic step(input logic [N-1:0] ar, input logic [N-1:0] dr,
                      input logic [N-1:0] en, input string tag);
    int a, d;
    logic       eas, eds;
    logic [N-1:0] eag, edg;
    @(negedge clk);
    addr_req = ar; data_req = dr; agent_en = en;
    a = pick(ar & en, pa);
    d = pick(dr & en, pd);
    if (a >= 0) begin eag = N'(1) << a; eas = 1'b1; pa = (a + 1) % N; end
    else begin eag = mag & en; eas = 1'b0; end
    if (d >= 0) begin edg = N'(1) << d; eds = 1'b1; pd = (d + 1) % N; end
    else begin edg = mdg & en; eds = 1'b0; end
    #1;
    check("R10 addr_gnt held before edge", 64'(addr_gnt), 64'(mag));
    @(posedge clk); #1;
    check({tag, " addr_gnt"},    64'(addr_gnt),    64'(eag));
    check({tag, " addr_strobe"}, 64'(addr_strobe), 64'(eas));
    check({tag, " data_gnt"},    64'(data_gnt),    64'(edg));
    check({tag, " data_start"},  64'(data_start),  64'(eds));
    mag = eag; mdg = edg;
  endtask

  task automatic qual_check(input logic [N*QW-1:0] aq, input logic [N*QW-1:0] dq);
    logic [QW-1:0] ea, ed;
    addr_qual_in = aq; data_qual_in = dq;
    ea = '0; ed = '0;
    for (int i = 0; i < N; i++) begin
      ea = ea | aq[i*QW +: QW];
      ed = ed | dq[i*QW +: QW];
    end
    #1;
    check("R11 addr_qual_out", 64'(addr_qual_out), 64'(ea));
    check("R11 data_qual_out", 64'(data_qual_out), 64'(ed));
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam logic [N-1:0] ALL = '1;

  initial begin
    pa = 0; pd = 0; mag = '0; mdg = '0;
    addr_req = ALL; data_req = ALL; agent_en = ALL;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset holds everything clear even with requests pending
    check("R1 addr_gnt in reset",    64'(addr_gnt),    64'd0);
    check("R1 addr_strobe in reset", 64'(addr_strobe), 64'd0);
    check("R1 data_gnt in reset",    64'(data_gnt),    64'd0);
    check("R1 data_start in reset",  64'(data_start),  64'd0);
    @(negedge clk);
    addr_req = '0; data_req = '0;
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 addr_gnt after reset", 64'(addr_gnt), 64'd0);
    check("R1 data_start after reset", 64'(data_start), 64'd0);

    // R3/R7: all agents request; grants rotate 0..14 and wrap
    for (int k = 0; k < 2 * N + 3; k++) step(ALL, ALL, ALL, "R3/R7 rotate");

    // R5/R8: idle cycles park on last owner
    for (int k = 0; k < 3; k++) step('0, '0, ALL, "R5/R8 park");

    // R3/R4: each single requester from every pointer position
    for (int p = 0; p < N; p++) begin
      for (int k = 0; k < N; k++) begin
        step(N'(1) << k, N'(1) << ((k + p) % N), ALL, "R3/R4 single sweep");
      end
    end

    // R6/R7: disabled agents requesting are skipped
    for (int k = 0; k < N; k++) step(ALL, ALL, ~(N'(1) << k) & ~(N'(1) << ((k+1) % N)), "R6/R7 mask");
    step(ALL, ALL, '0, "R6/R7 all disabled");
    step(ALL, ALL, N'(15'h0010), "R6/R7 only agent4");
    step('0, '0, N'(15'h0001), "R5 parked owner disabled");

    // R9: channels with disjoint patterns
    for (int k = 0; k < 20; k++) step(N'(15'h00FF), N'(15'h7F00), ALL, "R9 independent");
    for (int k = 0; k < 10; k++) step('0, ALL, ALL, "R9 data only");

    // R11: qualifier OR
    qual_check('0, '0);
    for (int i = 0; i < N; i++) qual_check((N*QW)'(4'h9) << (i*QW), (N*QW)'(4'h6) << (i*QW));
    qual_check('1, {(N*QW/4){4'h2}} ^ {(N*QW/4){4'h2}});
    for (int k = 0; k < 20; k++) begin
      seed = nxt(seed);
      qual_check({2{seed}}, {2{~seed}});
    end

    // R3..R9: pseudo-random traffic against the model
    for (int k = 0; k < 1500; k++) begin
      logic [31:0] s1, s2, s3;
      seed = nxt(seed); s1 = seed;
      seed = nxt(seed); s2 = seed;
      seed = nxt(seed); s3 = seed;
      step(s1[N-1:0] & s1[30:16], s2[N-1:0] & s2[30:16],
           ~(s3[N-1:0] & s3[30:16] & s3[15+:N]), "R3/R7 random");
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule